// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block runs one complete conversion and readout on a successive-approximation converter each time a start request arrives. It drives the converter's chip-select, a dedicated convert strobe and a serial clock. It shifts in the result one bit at a time and presents it as a parallel word with a one-cycle done pulse. Every timing minimum the converter imposes is a parameter in picoseconds. Each one is turned into a whole number of system-clock cycles by rounding up, so no interval ever comes out shorter than its minimum.

Two wirings are supported, chosen per request by a mode input. In separate-convert wiring, the convert strobe starts the conversion and chip-select only frames the readout. In tied wiring, chip-select is connected to the converter's convert pin. The block then holds it low for a quiet interval, and its rising edge starts the conversion. It stays high for the full conversion time, because ending it early would make the converter signal busy. Only after that does it fall again to frame the readout. A turbo selection shortens the conversion interval. Daisy-chain wiring, the reserved mode code, and wirings whose convert-output enable does not match the mode are all refused with an error pulse. No interface line moves on a refused request.

Top module: `sar_rdout_seq`

## Requirements
- R1: After reset and whenever the block is idle, cs_n_o is 1, cnv_o is 0 and sclk_o is 0. busy_o, done_o and err_o are all 0.
- R2: In tied wiring (mode_i = 1 with cnv_en_i = 0), cs_n_o is low for ceil(T_QUIET_PS/CLK_PS) cycles, starting the cycle after start_i is sampled. It is then high for the conversion interval, then low for the readout. cnv_o stays 0 throughout.
- R3: The conversion interval is ceil(T_CONV_PS/CLK_PS) cycles, or ceil(T_TURBO_PS/CLK_PS) cycles when turbo_i or always_turbo_i is 1 at the accepted start. The defaults give 53 and 40 cycles at an 8000 ps clock, and the quiet interval is 3 cycles.
- R4: In separate-convert wiring (mode_i = 0 with cnv_en_i = 1), cnv_o is low during the quiet interval and then high for exactly the conversion interval. cs_n_o stays high through both intervals and is low only during the readout.
- R5: The readout holds cs_n_o low for RES_W serial-clock periods. Each period is SCK_HALF cycles low followed by SCK_HALF cycles high. sclk_o is never high while cs_n_o is high.
- R6: Data is sampled on the rising edge of sclk_o, most significant bit first. result_o is right-aligned with its upper bits zero. Its width is 32 when RES_W is above 16 and 16 otherwise.
- R7: done_o is a one-cycle pulse in the cycle where cs_n_o returns high after the readout, and result_o is valid from then on. busy_o is 1 from the cycle after the accepted start up to the cycle before done_o.
- R8: A start_i while busy_o is 1 is ignored, whatever mode it carries. It changes no line timing and produces no err_o.
- R9: A start in mode 2 (chain), mode 3 (reserved), mode 0 with cnv_en_i = 0, or mode 1 with cnv_en_i = 1 gives a one-cycle err_o pulse the next cycle. It gives no done_o and no busy_o, and all interface lines stay idle.
- R10: Chain mode combined with always_turbo_i = 1 is also refused with the err_o pulse of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion and readout |
| mode_i | input | 2 | Wiring: 0 separate-convert, 1 tied, 2 chain, 3 reserved |
| cnv_en_i | input | 1 | A separate convert output is wired |
| turbo_i | input | 1 | Use the short conversion interval for this request |
| always_turbo_i | input | 1 | Converter is strapped for the short conversion interval |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip-select, active low (also the convert pin in tied wiring) |
| cnv_o | output | 1 | Dedicated convert strobe |
| sclk_o | output | 1 | Serial clock, idle low |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| err_o | output | 1 | One-cycle pulse when a request is refused |
| result_o | output | 32 (RES_W > 16) or 16 | Right-aligned conversion result |

## Verification
The bench predicts, for every cycle of a sequence, the level of chip-select, the convert strobe, the serial clock and busy. Any quiet or conversion interval that is off by one cycle, or that ignores turbo, shows up as a waveform mismatch. A design that cuts the tied-wiring high time short, or that drives the convert strobe in that wiring, is caught the same way. Result words with only the top bit, only the bottom bit, or every bit set expose bit-order reversal, a lost final bit and stray upper padding. Start requests issued mid-sequence carry the chain code, so a design that accepts them shows an error pulse or a disturbed waveform. Each refused configuration is checked for a lone error pulse with lines at rest.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Wiring codes carried on mode_i
    typedef enum logic [1:0] {
        WIRE_SEPARATE = 2'd0,
        WIRE_TIED     = 2'd1,
        WIRE_CHAIN    = 2'd2,
        WIRE_RSVD     = 2'd3
    } wire_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_QUIET = 2'd1,
        PH_CONV  = 2'd2,
        PH_READ  = 2'd3
    } phase_e;

    // Round a time up to whole clock cycles, never below one cycle.
    function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                              input int unsigned clk_ps);
        int unsigned n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n == 0) ? 1 : n;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sar_cfg_check.sv
module sar_cfg_check
    import sar_seq_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       cnv_en_i,
    output logic       accept_o,
    output logic       tied_o
);

    wire_mode_e mode_w;

    always_comb begin
        mode_w   = wire_mode_e'(mode_i);
        accept_o = 1'b0;
        tied_o   = 1'b0;
        case (mode_w)
            WIRE_SEPARATE: accept_o = cnv_en_i;
            WIRE_TIED: begin
                accept_o = !cnv_en_i;
                tied_o   = 1'b1;
            end
            // chain wiring, with or without always-turbo, and the reserved code
            default: accept_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign zero_o = (tmr_q.cnt == '0);

endmodule

// File: rtl/sar_rx_shift.sv
module sar_rx_shift #(
    parameter int RES_W = 18,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             sdo_i,
    output logic [OUT_W-1:0] word_o
);

    typedef struct packed {
        logic [RES_W-1:0] sh;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (clear_i) begin
            rx_d.sh = '0;
        end else if (shift_i) begin
            rx_d.sh = {rx_q.sh[RES_W-2:0], sdo_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    generate
        if (OUT_W > RES_W) begin : g_pad
            assign word_o = {{(OUT_W - RES_W){1'b0}}, rx_q.sh};
        end else begin : g_exact
            assign word_o = rx_q.sh[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/sar_rdout_seq.sv
module sar_rdout_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 18,
    parameter int CLK_PS     = 8000,
    parameter int T_QUIET_PS = 20000,
    parameter int T_CONV_PS  = 420000,
    parameter int T_TURBO_PS = 320000,
    parameter int SCK_HALF   = 2,
    localparam int OUT_W     = (RES_W > 16) ? 32 : 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             cnv_en_i,
    input  logic             turbo_i,
    input  logic             always_turbo_i,
    input  logic             sdo_i,
    output logic             cs_n_o,
    output logic             cnv_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [OUT_W-1:0] result_o
);

    localparam int unsigned QUIET_CYC = ps_to_cyc(T_QUIET_PS, CLK_PS);
    localparam int unsigned CONV_CYC  = ps_to_cyc(T_CONV_PS, CLK_PS);
    localparam int unsigned TURBO_CYC = ps_to_cyc(T_TURBO_PS, CLK_PS);
    localparam int unsigned HALF_CYC  = (SCK_HALF < 1) ? 1 : SCK_HALF;
    localparam int unsigned MAX_CYC   = max2(max2(QUIET_CYC, CONV_CYC), max2(TURBO_CYC, HALF_CYC));
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam int BIT_W = $clog2(RES_W);

    localparam logic [CNT_W-1:0] QUIET_LD = CNT_W'(QUIET_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_LD  = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] TURBO_LD = CNT_W'(TURBO_CYC - 1);
    localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(RES_W - 1);

    typedef struct packed {
        phase_e           ph;
        logic             tied;
        logic             turbo;
        logic             cs_n;
        logic             cnv;
        logic             sclk;
        logic [BIT_W-1:0] bit_idx;
        logic             busy;
        logic             done;
        logic             err;
        logic [OUT_W-1:0] result;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             cfg_ok;
    logic             cfg_tied;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             sh_clear;
    logic             sh_en;
    logic [OUT_W-1:0] sh_word;

    sar_cfg_check u_cfg (
        .mode_i   (mode_i),
        .cnv_en_i (cnv_en_i),
        .accept_o (cfg_ok),
        .tied_o   (cfg_tied)
    );

    sar_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    sar_rx_shift #(.RES_W(RES_W), .OUT_W(OUT_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (sh_clear),
        .shift_i (sh_en),
        .sdo_i   (sdo_i),
        .word_o  (sh_word)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        sh_clear   = 1'b0;
        sh_en      = 1'b0;

        case (seq_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    if (cfg_ok) begin
                        seq_d.ph    = PH_QUIET;
                        seq_d.tied  = cfg_tied;
                        seq_d.turbo = turbo_i | always_turbo_i;
                        seq_d.busy  = 1'b1;
                        // tied wiring pulls the convert pin low for the quiet time
                        seq_d.cs_n  = !cfg_tied;
                        seq_d.cnv   = 1'b0;
                        tmr_load    = 1'b1;
                        tmr_val     = QUIET_LD;
                        sh_clear    = 1'b1;
                    end else begin
                        seq_d.err = 1'b1;
                    end
                end
            end
            PH_QUIET: begin
                if (tmr_zero) begin
                    seq_d.ph   = PH_CONV;
                    seq_d.cs_n = 1'b1;
                    seq_d.cnv  = !seq_q.tied;
                    tmr_load   = 1'b1;
                    tmr_val    = seq_q.turbo ? TURBO_LD : CONV_LD;
                end
            end
            PH_CONV: begin
                if (tmr_zero) begin
                    seq_d.ph      = PH_READ;
                    seq_d.cs_n    = 1'b0;
                    seq_d.cnv     = 1'b0;
                    seq_d.sclk    = 1'b0;
                    seq_d.bit_idx = '0;
                    tmr_load      = 1'b1;
                    tmr_val       = HALF_LD;
                end
            end
            PH_READ: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = HALF_LD;
                    if (!seq_q.sclk) begin
                        seq_d.sclk = 1'b1;
                        sh_en      = 1'b1;
                    end else begin
                        seq_d.sclk = 1'b0;
                        if (seq_q.bit_idx == LAST_BIT) begin
                            seq_d.ph     = PH_IDLE;
                            seq_d.cs_n   = 1'b1;
                            seq_d.busy   = 1'b0;
                            seq_d.done   = 1'b1;
                            seq_d.result = sh_word;
                        end else begin
                            seq_d.bit_idx = seq_q.bit_idx + 1'b1;
                        end
                    end
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.ph   <= PH_IDLE;
            seq_q.cs_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n_o   = seq_q.cs_n;
    assign cnv_o    = seq_q.cnv;
    assign sclk_o   = seq_q.sclk;
    assign busy_o   = seq_q.busy;
    assign done_o   = seq_q.done;
    assign err_o    = seq_q.err;
    assign result_o = seq_q.result;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cs_n_o,
    input logic cnv_o,
    input logic sclk_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !cnv_o && !sclk_o));

    // R4
    cnv_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_o |-> (cs_n_o && !sclk_o));

    // R5
    sclk_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o) && !err_o));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !err_o);

    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && cs_n_o && !cnv_o && !sclk_o));

endmodule

bind sar_rdout_seq sar_seq_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cs_n_o  (cs_n_o),
    .cnv_o   (cnv_o),
    .sclk_o  (sclk_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o)
);

// File: tb/sar_rdout_seq_tb_top.sv
module sar_rdout_seq_tb_top;

    localparam int RES   = 18;
    localparam int OUTW  = 32;
    localparam int HALF  = 2;
    localparam int CLKPS = 8000;

    function automatic int cyc(input int t_ps);
        return (t_ps + CLKPS - 1) / CLKPS;
    endfunction

    localparam int QC = cyc(20000);
    localparam int CN = cyc(420000);
    localparam int CT = cyc(320000);
    localparam int RD = RES * 2 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            start_i = 1'b0;
    logic [1:0]      mode_i = 2'd0;
    logic            cnv_en_i = 1'b0;
    logic            turbo_i = 1'b0;
    logic            always_turbo_i = 1'b0;
    logic            sdo_i;
    logic            cs_n_o, cnv_o, sclk_o, busy_o, done_o, err_o;
    logic [OUTW-1:0] result_o;

    sar_rdout_seq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .mode_i         (mode_i),
        .cnv_en_i       (cnv_en_i),
        .turbo_i        (turbo_i),
        .always_turbo_i (always_turbo_i),
        .sdo_i          (sdo_i),
        .cs_n_o         (cs_n_o),
        .cnv_o          (cnv_o),
        .sclk_o         (sclk_o),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .err_o          (err_o),
        .result_o       (result_o)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // converter model: presents bit (RES-1-rises) of adc_word
    logic [RES-1:0] adc_word = '0;
    int  rcnt = 0;
    logic sclk_prev = 1'b0;
    always @(negedge clk) begin
        if (cs_n_o) rcnt = 0;
        else if (sclk_o && !sclk_prev) rcnt = rcnt + 1;
        sclk_prev = sclk_o;
        sdo_i = (rcnt < RES) ? adc_word[RES-1-rcnt] : 1'b0;
    end

    task automatic run_ok(input logic [1:0] m, input bit tb, input bit at,
                          input logic [RES-1:0] w, input int restart_at);
        int  clen = (tb || at) ? CT : CN;
        int  tot  = QC + clen + RD;
        bit  tied = (m == 2'd1);
        int  bad_cs = 0, bad_cnv = 0, bad_sclk = 0, bad_busy = 0, errs = 0;
        logic [OUTW-1:0] res_seen = '0;
        adc_word = w;
        @(negedge clk);
        mode_i = m; cnv_en_i = !tied; turbo_i = tb; always_turbo_i = at; start_i = 1'b1;
        for (int k = 1; k <= tot + 1; k++) begin
            bit in_rd, e_cs, e_cnv, e_sclk, e_busy, e_done;
            @(negedge clk);
            start_i = 1'b0;
            mode_i  = m;
            in_rd   = (k > QC + clen) && (k <= tot);
            if (tied) e_cs = (k <= QC) ? 1'b0 : (k <= QC + clen) ? 1'b1 : !in_rd;
            else      e_cs = !in_rd;
            e_cnv  = !tied && (k > QC) && (k <= QC + clen);
            e_sclk = in_rd && (((k - QC - clen - 1) % (2 * HALF)) >= HALF);
            e_busy = (k <= tot);
            e_done = (k == tot + 1);
            if (cs_n_o !== e_cs) bad_cs++;
            if (cnv_o !== e_cnv) bad_cnv++;
            if (sclk_o !== e_sclk) bad_sclk++;
            if (busy_o !== e_busy || done_o !== e_done) bad_busy++;
            if (err_o) errs++;
            if (k == tot + 1) res_seen = result_o;
            if (k == restart_at) begin
                start_i = 1'b1;
                mode_i  = 2'd2;
            end
        end
        @(negedge clk);
        if (done_o || busy_o || !cs_n_o) bad_busy++;
        if (tied) chk(bad_cs == 0, "R2 R3", "tied cs_n cycles wrong", bad_cs, 0);
        else      chk(bad_cs == 0, "R4", "separate cs_n cycles wrong", bad_cs, 0);
        if (tied) chk(bad_cnv == 0, "R2", "cnv driven in tied wiring", bad_cnv, 0);
        else      chk(bad_cnv == 0, "R3 R4", "cnv cycles wrong", bad_cnv, 0);
        chk(bad_sclk == 0, "R5", "sclk cycles wrong", bad_sclk, 0);
        chk(bad_busy == 0, "R7", "busy/done cycles wrong", bad_busy, 0);
        chk(res_seen == {{(OUTW-RES){1'b0}}, w}, "R6", "result", res_seen, {{(OUTW-RES){1'b0}}, w});
        if (restart_at > 0) chk(errs == 0, "R8", "restart while busy produced err", errs, 0);
    endtask

    task automatic run_bad(input logic [1:0] m, input bit ce, input bit at, input string req);
        int bad = 0;
        @(negedge clk);
        mode_i = m; cnv_en_i = ce; turbo_i = 1'b0; always_turbo_i = at; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o && !done_o && !busy_o, req, "err pulse missing", {err_o, done_o, busy_o}, 3'b100);
        for (int k = 0; k < 4; k++) begin
            if (err_o && k > 0) bad++;
            if (done_o || busy_o || !cs_n_o || cnv_o || sclk_o) bad++;
            @(negedge clk);
        end
        chk(bad == 0, req, "lines moved or err stretched", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n_o && !cnv_o && !sclk_o, "R1", "idle lines after reset",
            {cs_n_o, cnv_o, sclk_o}, 3'b100);
        chk(!busy_o && !done_o && !err_o, "R1", "status after reset",
            {busy_o, done_o, err_o}, 3'b000);

        // directed corner cases
        run_ok(2'd1, 1'b0, 1'b0, 18'h3FFFF, 0);
        run_ok(2'd0, 1'b0, 1'b0, 18'h00001, 0);
        run_ok(2'd1, 1'b1, 1'b0, 18'h20000, 0);
        run_ok(2'd0, 1'b0, 1'b1, 18'h2A5A5, 0);
        run_ok(2'd1, 1'b0, 1'b0, 18'h15A5A, 2);
        run_ok(2'd0, 1'b1, 1'b0, 18'h0F0F0, QC + 5);
        run_ok(2'd1, 1'b0, 1'b0, 18'h12345, QC + CN + 7);

        run_bad(2'd2, 1'b1, 1'b0, "R9");
        run_bad(2'd3, 1'b0, 1'b0, "R9");
        run_bad(2'd0, 1'b0, 1'b0, "R9");
        run_bad(2'd1, 1'b1, 1'b0, "R9");
        run_bad(2'd2, 1'b0, 1'b1, "R10");

        // constrained random
        void'($urandom(32'h5EED));
        for (int i = 0; i < 20; i++) begin
            logic [1:0] m = 2'($urandom_range(0, 1));
            bit tb = 1'($urandom_range(0, 1));
            bit at = ($urandom_range(0, 3) == 0);
            logic [RES-1:0] w = RES'($urandom);
            int ra = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, QC + CT)) : 0;
            run_ok(m, tb, at, w, ra);
        end
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
        report();
    end

endmodule